// File: doc/BRIEF.md
# Mock Unification Associative Memory

This block keeps a small store of symbolic expressions, each held as a sequence of up to 16 tokens. A query expression is compared against every stored expression, and the block reports which ones could unify with it. The comparison is structural. In the default mode a variable on either side stands for anything that fills one position of the other side: a single atom, a single variable, or a whole parenthesised group. No bindings are kept, so the same variable may stand for different things at different positions. The result only marks candidates. A later full unifier must still confirm each one.

Expressions arrive over two valid/ready token streams. The write stream fills one entry with a burst of tokens, ending with a last flag. The query stream loads the query, and its last token starts the search. A transfer takes place on a rising edge where both valid and ready are high. While a search runs, both ready outputs stay low. Any valid held high during that time simply waits, and nothing is taken from either stream. Each of `N_UNITS` parallel match units walks one entry per pass, and the block runs `N_ENT/N_UNITS` passes to cover the store. The result vector and a one-cycle done pulse then appear on plain output pins. A mode pin selects literal structural equality instead of mock unification.

Top module: `mock_unify_cam`

## Requirements
- R1: After reset, every entry is empty and never matches, `done` is 0, `match_vec` is 0 and both ready outputs are 1.
- R2: Token kind codes are 0 for atom, 1 for open parenthesis, 2 for close parenthesis and 3 for variable. Two atoms match only when their 14-bit values are equal. The values of open and close tokens are not compared.
- R3: With `mode_exact`=0, a variable on either side matches one atom, one variable, or a whole balanced parenthesised group opposite it. No binding is kept, so `( f X X )` matches `( f a b )`.
- R4: With `mode_exact`=1, a variable matches only a variable with the same value, exactly as an atom would.
- R5: If the entry and the query have different lengths after matching, or if a variable meets a close parenthesis, the result is no match.
- R6: If either side has unbalanced parentheses, the result is no match.
- R7: Expressions of exactly 16 tokens are compared normally. An entry that received more than 16 tokens never matches. A query of more than 16 tokens gives an all-zero result.
- R8: A write burst replaces the whole entry selected by `wr_entry`, and the entry becomes valid when the token flagged `wr_last` is accepted.
- R9: The search starts when the last query token is accepted. From then until `done`, both ready outputs are 0 and neither stream accepts anything. `done` lasts one cycle. `match_vec` is valid during `done` and holds its value until the next `done`.
- R10: Bit k of `match_vec` is the result for entry k. Every entry is compared, over `N_ENT/N_UNITS` passes, and `done` comes within `N_ENT/N_UNITS*(2*MAX_TOK+4)` cycles of the last query token.
- R11: `mode_exact` is sampled together with the last query token and has no effect at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write token valid |
| wr_ready | output | 1 | Write token accepted when high |
| wr_entry | input | $clog2(N_ENT) | Entry being written |
| wr_kind | input | 2 | Write token kind |
| wr_value | input | 14 | Write token value |
| wr_last | input | 1 | Last token of the entry |
| q_valid | input | 1 | Query token valid |
| q_ready | output | 1 | Query token accepted when high |
| q_kind | input | 2 | Query token kind |
| q_value | input | 14 | Query token value |
| q_last | input | 1 | Last query token; starts the search |
| mode_exact | input | 1 | 1 = literal equality, 0 = mock unification |
| done | output | 1 | One-cycle search-complete pulse |
| match_vec | output | N_ENT | Candidate flag per entry |

## Verification
The bench builds the block with 8 entries and only 2 match units. This forces four passes per search, so the result of every pass has to be merged into the right bit positions. Each query runs against a mixed store. The store holds a 16-token entry, an entry that overflowed to 17 tokens, an unbalanced entry, an entry with a nested group and an entry that was never written. One query therefore reaches variable-over-group skipping, the length boundary, invalid entries and the pass merge all at once.

// File: rtl/mua_pkg.sv
package mua_pkg;
  localparam int TOK_VAL_W = 14;

  typedef enum logic [1:0] {
    TK_ATOM  = 2'd0,
    TK_OPEN  = 2'd1,
    TK_CLOSE = 2'd2,
    TK_VAR   = 2'd3
  } tok_kind_e;

  typedef struct packed {
    tok_kind_e            kind;
    logic [TOK_VAL_W-1:0] val;
  } token_t;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_START = 2'd1,
    SQ_RUN   = 2'd2
  } seq_state_e;
endpackage

// File: rtl/mua_entry_store.sv
module mua_entry_store
  import mua_pkg::*;
#(
  parameter int N_ENT   = 8,
  parameter int N_RD    = 4,
  parameter int MAX_TOK = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [$clog2(N_ENT)-1:0]   wr_idx,
  input  token_t                     wr_tok,
  input  logic                       wr_last,
  input  logic [$clog2(N_ENT)-1:0]   rd_idx [N_RD],
  output token_t                     rd_toks [N_RD][MAX_TOK],
  output logic [$clog2(MAX_TOK+1)-1:0] rd_len [N_RD],
  output logic                       rd_ok [N_RD],
  output logic [N_ENT-1:0]           ent_ok
);
  localparam int LW = $clog2(MAX_TOK + 1);
  localparam int TW = $clog2(MAX_TOK);

  token_t            mem   [N_ENT][MAX_TOK];
  logic [LW-1:0]     len_q [N_ENT];
  logic [N_ENT-1:0]  valid_q;
  logic [N_ENT-1:0]  bad_q;
  logic [LW-1:0]     wpos;

  // token data carries no reset
  always_ff @(posedge clk) begin
    if (wr_en && (wpos < LW'(MAX_TOK)))
      mem[wr_idx][wpos[TW-1:0]] <= wr_tok;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      bad_q   <= '0;
      wpos    <= '0;
      for (int k = 0; k < N_ENT; k++) len_q[k] <= '0;
    end else if (wr_en) begin
      if (wpos == '0) begin
        valid_q[wr_idx] <= 1'b0;
        bad_q[wr_idx]   <= 1'b0;
      end
      if (wpos == LW'(MAX_TOK)) bad_q[wr_idx] <= 1'b1;
      if (wr_last) begin
        valid_q[wr_idx] <= 1'b1;
        len_q[wr_idx]   <= (wpos < LW'(MAX_TOK)) ? wpos + 1'b1 : LW'(MAX_TOK);
        wpos            <= '0;
      end else if (wpos < LW'(MAX_TOK)) begin
        wpos <= wpos + 1'b1;
      end
    end
  end

  assign ent_ok = valid_q & ~bad_q;

  always_comb begin
    for (int r = 0; r < N_RD; r++) begin
      rd_toks[r] = mem[rd_idx[r]];
      rd_len[r]  = len_q[rd_idx[r]];
      rd_ok[r]   = ent_ok[rd_idx[r]];
    end
  end

  for (genvar k = 0; k < N_ENT; k++) begin : g_len_chk
    assert_len_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      len_q[k] <= LW'(MAX_TOK));
  end
endmodule

// File: rtl/mua_match_unit.sv
module mua_match_unit
  import mua_pkg::*;
#(
  parameter int MAX_TOK = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic                         unify,
  input  token_t                       e_toks [MAX_TOK],
  input  logic [$clog2(MAX_TOK+1)-1:0] e_len,
  input  logic                         e_ok,
  input  token_t                       q_toks [MAX_TOK],
  input  logic [$clog2(MAX_TOK+1)-1:0] q_len,
  input  logic                         q_ok,
  output logic                         busy,
  output logic                         hit
);
  localparam int LW = $clog2(MAX_TOK + 1);
  localparam int TW = $clog2(MAX_TOK);

  logic          running;
  logic [LW-1:0] ip, jp, nest, sd;
  logic          skip_e, skip_q;

  logic [LW-1:0] n_ip, n_jp, n_nest, n_sd;
  logic          n_se, n_sq, stop, ok, e_end, q_end;
  token_t        a, b, sk;

  always_comb begin
    n_ip = ip; n_jp = jp; n_nest = nest; n_sd = sd;
    n_se = skip_e; n_sq = skip_q;
    stop = 1'b0; ok = 1'b0;
    e_end = (ip >= e_len);
    q_end = (jp >= q_len);
    a  = e_toks[ip[TW-1:0]];
    b  = q_toks[jp[TW-1:0]];
    sk = skip_e ? a : b;
    if (!e_ok || !q_ok) begin
      stop = 1'b1;
    end else if (skip_e || skip_q) begin
      // one side swallows a group opposite a variable
      if (skip_e ? e_end : q_end) begin
        stop = 1'b1;
      end else begin
        if (skip_e) n_ip = ip + 1'b1;
        else        n_jp = jp + 1'b1;
        if (sk.kind == TK_OPEN) begin
          n_sd = sd + 1'b1;
        end else if (sk.kind == TK_CLOSE) begin
          n_sd = sd - 1'b1;
          if (sd == LW'(1)) begin
            n_se = 1'b0;
            n_sq = 1'b0;
          end
        end
      end
    end else if (e_end || q_end) begin
      stop = 1'b1;
      ok   = e_end && q_end && (nest == '0);
    end else if (unify && (a.kind == TK_VAR || b.kind == TK_VAR)) begin
      n_ip = ip + 1'b1;
      n_jp = jp + 1'b1;
      if (a.kind == TK_VAR && b.kind != TK_VAR) begin
        if (b.kind == TK_CLOSE) stop = 1'b1;
        else if (b.kind == TK_OPEN) begin
          n_sq = 1'b1;
          n_sd = LW'(1);
        end
      end else if (a.kind != TK_VAR) begin
        if (a.kind == TK_CLOSE) stop = 1'b1;
        else if (a.kind == TK_OPEN) begin
          n_se = 1'b1;
          n_sd = LW'(1);
        end
      end
    end else if (a.kind != b.kind) begin
      stop = 1'b1;
    end else begin
      n_ip = ip + 1'b1;
      n_jp = jp + 1'b1;
      case (a.kind)
        TK_OPEN:  n_nest = nest + 1'b1;
        TK_CLOSE: begin
          if (nest == '0) stop = 1'b1;
          else            n_nest = nest - 1'b1;
        end
        default:  if (a.val != b.val) stop = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0; hit <= 1'b0;
      ip <= '0; jp <= '0; nest <= '0; sd <= '0;
      skip_e <= 1'b0; skip_q <= 1'b0;
    end else if (start) begin
      running <= 1'b1; hit <= 1'b0;
      ip <= '0; jp <= '0; nest <= '0; sd <= '0;
      skip_e <= 1'b0; skip_q <= 1'b0;
    end else if (running) begin
      if (stop) begin
        running <= 1'b0;
        hit     <= ok;
      end else begin
        ip <= n_ip; jp <= n_jp; nest <= n_nest; sd <= n_sd;
        skip_e <= n_se; skip_q <= n_sq;
      end
    end
  end

  assign busy = running;

  assert_skip_one_side_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(skip_e && skip_q));
  assert_start_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !running);
  assert_ptr_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ip <= LW'(MAX_TOK)) && (jp <= LW'(MAX_TOK)));
endmodule

// File: rtl/mock_unify_cam.sv
module mock_unify_cam
  import mua_pkg::*;
#(
  parameter int N_ENT   = 8,
  parameter int N_UNITS = 4,
  parameter int MAX_TOK = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_valid,
  output logic                       wr_ready,
  input  logic [$clog2(N_ENT)-1:0]   wr_entry,
  input  logic [1:0]                 wr_kind,
  input  logic [TOK_VAL_W-1:0]       wr_value,
  input  logic                       wr_last,
  input  logic                       q_valid,
  output logic                       q_ready,
  input  logic [1:0]                 q_kind,
  input  logic [TOK_VAL_W-1:0]       q_value,
  input  logic                       q_last,
  input  logic                       mode_exact,
  output logic                       done,
  output logic [N_ENT-1:0]           match_vec
);
  localparam int EIW    = $clog2(N_ENT);
  localparam int LW     = $clog2(MAX_TOK + 1);
  localparam int TW     = $clog2(MAX_TOK);
  localparam int N_PASS = N_ENT / N_UNITS;
  localparam int PW     = (N_PASS > 1) ? $clog2(N_PASS) : 1;

  seq_state_e       state;
  logic [PW-1:0]    pass;
  token_t           qmem [MAX_TOK];
  logic [LW-1:0]    qpos, qlen;
  logic             qbad, mode_r;
  logic [N_ENT-1:0] acc, acc_next;

  logic [EIW-1:0]   rd_idx  [N_UNITS];
  token_t           u_etoks [N_UNITS][MAX_TOK];
  logic [LW-1:0]    u_elen  [N_UNITS];
  logic             u_eok   [N_UNITS];
  logic [N_UNITS-1:0] u_busy, u_hit;
  logic [N_ENT-1:0] ent_ok;

  logic wr_take, q_take, unit_go;

  assign wr_ready = (state == SQ_IDLE);
  assign q_ready  = (state == SQ_IDLE);
  assign wr_take  = wr_valid && wr_ready;
  assign q_take   = q_valid && q_ready;
  assign unit_go  = (state == SQ_START);

  mua_entry_store #(.N_ENT(N_ENT), .N_RD(N_UNITS), .MAX_TOK(MAX_TOK)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_take),
    .wr_idx  (wr_entry),
    .wr_tok  (token_t'{kind: tok_kind_e'(wr_kind), val: wr_value}),
    .wr_last (wr_last),
    .rd_idx  (rd_idx),
    .rd_toks (u_etoks),
    .rd_len  (u_elen),
    .rd_ok   (u_eok),
    .ent_ok  (ent_ok)
  );

  for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
    assign rd_idx[u] = EIW'(int'(pass) * N_UNITS + u);
    mua_match_unit #(.MAX_TOK(MAX_TOK)) u_match (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (unit_go),
      .unify  (!mode_r),
      .e_toks (u_etoks[u]),
      .e_len  (u_elen[u]),
      .e_ok   (u_eok[u]),
      .q_toks (qmem),
      .q_len  (qlen),
      .q_ok   (!qbad),
      .busy   (u_busy[u]),
      .hit    (u_hit[u])
    );
  end

  always_comb begin
    acc_next = acc;
    for (int k = 0; k < N_ENT; k++)
      if ((k / N_UNITS) == int'(pass)) acc_next[k] = u_hit[k % N_UNITS];
  end

  // query token capture
  always_ff @(posedge clk) begin
    if (q_take && (qpos < LW'(MAX_TOK)))
      qmem[qpos[TW-1:0]] <= token_t'{kind: tok_kind_e'(q_kind), val: q_value};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= SQ_IDLE; pass <= '0; qpos <= '0; qlen <= '0;
      qbad <= 1'b0; mode_r <= 1'b0; acc <= '0;
      match_vec <= '0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        SQ_IDLE: if (q_take) begin
          if (qpos == '0)            qbad <= 1'b0;
          if (qpos == LW'(MAX_TOK))  qbad <= 1'b1;
          if (q_last) begin
            qlen   <= (qpos < LW'(MAX_TOK)) ? qpos + 1'b1 : LW'(MAX_TOK);
            qpos   <= '0;
            mode_r <= mode_exact;
            pass   <= '0;
            state  <= SQ_START;
          end else if (qpos < LW'(MAX_TOK)) begin
            qpos <= qpos + 1'b1;
          end
        end
        SQ_START: state <= SQ_RUN;
        SQ_RUN: if (!(|u_busy)) begin
          acc <= acc_next;
          if (pass == PW'(N_PASS - 1)) begin
            match_vec <= acc_next;
            done      <= 1'b1;
            state     <= SQ_IDLE;
          end else begin
            pass  <= pass + 1'b1;
            state <= SQ_START;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assert_done_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_ready_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (q_ready && wr_ready));
  assert_units_quiet_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    q_ready |-> !(|u_busy));
  assert_invalid_no_hit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((match_vec & ~ent_ok) == '0));
endmodule

// File: tb/mock_unify_cam_bench.sv
module mock_unify_cam_bench;
  localparam int NE = 8;
  localparam int NU = 2;
  localparam int MT = 16;
  localparam int BOUND = (NE / NU) * (2 * MT + 4);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0, wr_last = 1'b0, q_valid = 1'b0, q_last = 1'b0;
  logic mode_exact = 1'b0;
  logic [2:0] wr_entry = '0;
  logic [1:0] wr_kind = '0, q_kind = '0;
  logic [13:0] wr_value = '0, q_value = '0;
  logic wr_ready, q_ready, done;
  logic [NE-1:0] match_vec;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  mock_unify_cam #(.N_ENT(NE), .N_UNITS(NU), .MAX_TOK(MT)) u_mock_unify_cam (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_entry(wr_entry),
    .wr_kind(wr_kind), .wr_value(wr_value), .wr_last(wr_last),
    .q_valid(q_valid), .q_ready(q_ready), .q_kind(q_kind),
    .q_value(q_value), .q_last(q_last), .mode_exact(mode_exact),
    .done(done), .match_vec(match_vec)
  );

  // reference model state
  int  ek [NE][20];
  int  ev [NE][20];
  int  eln [NE];
  bit  evl [NE];
  int  qk [20], qv [20], qln;
  bit  qex;
  int  sk [20], sv [20], slen;

  task automatic chk(bit cond, string tag, longint act, longint exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit bal_seq(bit is_q, int k);
    int d = 0;
    int n = is_q ? qln : eln[k];
    for (int i = 0; i < n; i++) begin
      int kk = is_q ? qk[i] : ek[k][i];
      if (kk == 1) d++;
      if (kk == 2) begin d--; if (d < 0) return 1'b0; end
    end
    return d == 0;
  endfunction

  function automatic int span(bit is_q, int k, int pos);
    int n = is_q ? qln : eln[k];
    int kk = is_q ? qk[pos] : ek[k][pos];
    int d = 0;
    if (kk == 0 || kk == 3) return pos + 1;
    if (kk == 2) return -1;
    for (int i = pos; i < n; i++) begin
      int t = is_q ? qk[i] : ek[k][i];
      if (t == 1) d++;
      if (t == 2) begin d--; if (d == 0) return i + 1; end
    end
    return -1;
  endfunction

  function automatic bit ref_match(int k);
    int i = 0, j = 0, s;
    if (!evl[k] || eln[k] > MT || qln > MT) return 1'b0;
    if (!bal_seq(1'b0, k) || !bal_seq(1'b1, k)) return 1'b0;
    while (i < eln[k] && j < qln) begin
      int a = ek[k][i], b = qk[j];
      if (!qex && (a == 3 || b == 3)) begin
        if (a == 3 && b == 3) begin i++; j++; end
        else if (a == 3) begin s = span(1'b1, k, j); if (s < 0) return 1'b0; i++; j = s; end
        else begin s = span(1'b0, k, i); if (s < 0) return 1'b0; j++; i = s; end
      end else begin
        if (a != b) return 1'b0;
        if ((a == 0 || a == 3) && ev[k][i] != qv[j]) return 1'b0;
        i++; j++;
      end
    end
    return (i == eln[k]) && (j == qln);
  endfunction

  task automatic clr(); slen = 0; endtask
  task automatic add(int k, int v); sk[slen] = k; sv[slen] = v; slen++; endtask

  task automatic write_entry(int idx);
    for (int t = 0; t < slen; t++) begin
      bit r = 1'b0;
      wr_valid = 1'b1; wr_entry = 3'(idx); wr_kind = 2'(sk[t]);
      wr_value = 14'(sv[t]); wr_last = (t == slen - 1);
      while (!r) begin r = wr_ready; @(negedge clk); end
      ek[idx][t] = sk[t]; ev[idx][t] = sv[t];
    end
    wr_valid = 1'b0; wr_last = 1'b0;
    eln[idx] = slen; evl[idx] = 1'b1;
  endtask

  task automatic run_query(string tag, bit md, bit md_last, bit poke);
    logic [NE-1:0] exp;
    int cyc = 0;
    for (int t = 0; t < slen; t++) begin
      bit r = 1'b0;
      q_valid = 1'b1; q_kind = 2'(sk[t]); q_value = 14'(sv[t]);
      q_last = (t == slen - 1); mode_exact = (t == slen - 1) ? md_last : md;
      while (!r) begin r = q_ready; @(negedge clk); end
      qk[t] = sk[t]; qv[t] = sv[t];
    end
    q_valid = 1'b0; q_last = 1'b0;
    mode_exact = ~md_last;   // R11: later changes must not matter
    qln = slen; qex = md_last;
    for (int k = 0; k < NE; k++) exp[k] = ref_match(k);
    if (poke) begin
      wr_valid = 1'b1; wr_entry = 3'd0; wr_kind = 2'd0; wr_value = 14'h3FFF; wr_last = 1'b1;
      q_valid = 1'b1; q_kind = 2'd0; q_value = 14'h1; q_last = 1'b1;
    end
    while (1) begin
      if (done) begin
        chk(match_vec == exp, {tag, " result R10"}, match_vec, exp);
        break;
      end
      chk(!q_ready && !wr_ready, "busy ready low R9", {q_ready, wr_ready}, 0);
      cyc++;
      if (cyc > BOUND) begin
        chk(1'b0, "done latency R10", cyc, BOUND);
        break;
      end
      @(negedge clk);
    end
    wr_valid = 1'b0; q_valid = 1'b0; wr_last = 1'b0; q_last = 1'b0;
    @(negedge clk);
    chk(!done, "done single pulse R9", done, 0);
    chk(match_vec == exp, "match_vec held R9", match_vec, exp);
  endtask

  initial begin
    for (int k = 0; k < NE; k++) begin evl[k] = 1'b0; eln[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(wr_ready && q_ready, "reset ready R1", {wr_ready, q_ready}, 3);
    chk(!done, "reset done R1", done, 0);
    chk(match_vec == '0, "reset vec R1", match_vec, 0);
    clr(); add(3, 10);
    run_query("empty store R1", 1'b0, 1'b0, 1'b0);

    // store: values f=1 a=2 b=3 g=4, vars X=10 Y=11
    clr(); add(1,0); add(0,1); add(0,2); add(0,3); add(2,0); write_entry(0);
    clr(); add(1,0); add(0,1); add(3,10); add(0,3); add(2,0); write_entry(1);
    clr(); add(1,0); add(0,1); add(1,0); add(0,4); add(0,2); add(2,0); add(0,3); add(2,0); write_entry(2);
    clr(); add(0,2); write_entry(3);
    clr(); add(1,0); add(0,1); for (int t = 0; t < 13; t++) add(0,2); add(2,0); write_entry(4);
    clr(); add(1,0); add(0,1); for (int t = 0; t < 14; t++) add(0,2); add(2,0); write_entry(5);
    clr(); add(1,0); add(0,1); add(0,2); write_entry(6);

    clr(); add(1,0); add(0,1); add(0,2); add(0,3); add(2,0);
    run_query("atom query R2", 1'b0, 1'b0, 1'b0);
    clr(); add(1,9); add(0,1); add(0,2); add(0,3); add(2,7);
    run_query("paren value ignored R2", 1'b1, 1'b1, 1'b0);
    clr(); add(1,0); add(0,1); add(3,11); add(0,3); add(2,0);
    run_query("var over group R3", 1'b0, 1'b0, 1'b0);
    clr(); add(3,10);
    run_query("lone var R3", 1'b0, 1'b0, 1'b0);
    clr(); add(1,0); add(0,1); add(3,10); add(3,10); add(2,0);
    run_query("no binding R3", 1'b0, 1'b0, 1'b0);
    clr(); add(1,0); add(0,1); add(3,10); add(0,3); add(2,0);
    run_query("exact var R4", 1'b1, 1'b1, 1'b0);
    clr(); add(1,0); add(0,1); add(3,11); add(0,3); add(2,0);
    run_query("exact var value R4", 1'b1, 1'b1, 1'b0);
    clr(); add(1,0); add(0,1); add(0,2); add(2,0);
    run_query("length mismatch R5", 1'b0, 1'b0, 1'b0);
    clr(); add(1,0); add(0,1); add(0,2); add(0,3); add(3,10); add(2,0);
    run_query("var vs close R5", 1'b0, 1'b0, 1'b0);
    clr(); add(1,0); add(0,1); add(0,2);
    run_query("unbalanced query R6", 1'b0, 1'b0, 1'b0);
    clr(); add(1,0); add(0,1); add(3,10); add(2,0); add(2,0);
    run_query("extra close R6", 1'b0, 1'b0, 1'b0);
    clr(); add(1,0); add(0,1); for (int t = 0; t < 13; t++) add(0,2); add(2,0);
    run_query("16 token query R7", 1'b1, 1'b1, 1'b0);
    clr(); add(1,0); add(0,1); for (int t = 0; t < 14; t++) add(0,2); add(2,0);
    run_query("17 token query R7", 1'b0, 1'b0, 1'b0);
    clr(); add(1,0); add(0,1); add(0,2); add(0,3); add(2,0);
    run_query("mode at last R11", 1'b1, 1'b0, 1'b1);
    run_query("ignored while busy R9", 1'b0, 1'b0, 1'b0);
    clr(); add(1,0); add(0,1); add(0,2); add(0,3); add(2,0); write_entry(3);
    clr(); add(1,0); add(0,1); add(0,2); add(0,3); add(2,0);
    run_query("rewrite entry R8", 1'b0, 1'b0, 1'b0);

    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog R10: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule